// File: doc/BRIEF.md
# Word Atomic Memory Sequencer

This block sits between a simple in-order core and a single-port word memory and carries out one memory operation at a time on the core's behalf. It handles plain word loads and stores and the word atomics: load-reserved, store-conditional, and read-modify-write operations (swap, add, and, or, xor, signed and unsigned min and max). A read-modify-write reads the word, merges it with the source operand, writes the result back, and returns the old memory value. No other memory request is issued between that read and that write.

A single reservation register supports the load-reserved / store-conditional pair. Load-reserved records the word address. Store-conditional writes only when the held reservation is for exactly its address. It returns zero on success and one on failure, and it always leaves the reservation cleared. Ordering hint bits arrive with each request but change nothing.

The core side is a valid/ready request channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high, and the fields are sampled only on that edge. `req_ready` then stays low until the response has been presented. The response is a single-cycle `rsp_valid` pulse with no back-pressure. The core must be able to take it in that cycle. The memory side has no stall: a read returns data on the cycle after its request.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and no reservation is held, so a store-conditional issued first fails with result 1.
- R2: In every cycle after a request is accepted, up to and including the cycle in which `rsp_valid` is high, `req_ready` is 0. `req_ready` returns to 1 in the next cycle, and `rsp_valid` is high for exactly one cycle per accepted request.
- R3: `rsp_valid` rises 0, 1, 2 or 3 cycles after the accepting edge's following cycle. The count is 0 for an error or a failed store-conditional, 1 for a store or a successful store-conditional, 2 for a load or load-reserved, and 3 for a read-modify-write.
- R4: Op codes are 0 load, 1 store, 2 load-reserved, 3 store-conditional, 4 swap, 5 add, 6 and, 7 or, 8 xor, 9 signed min, 10 signed max, 11 unsigned min, and 12 unsigned max. A read-modify-write writes the function of the old word and `req_wdata`, wrapping on overflow, and returns the old word.
- R5: Each operation issues a fixed number of memory requests. An error or a failed store-conditional issues none. A load, load-reserved, store or successful store-conditional issues one. A read-modify-write issues a read, one cycle with no request, and then a write to the same address.
- R6: Load-reserved returns the memory word and sets the reservation to its address, replacing any earlier one.
- R7: Store-conditional writes `req_wdata` and returns 0 only if the reservation is held for its exact address. Otherwise it leaves memory unchanged and returns 1. In both cases the reservation is cleared.
- R8: A store or read-modify-write to the reserved address clears the reservation. A store to a different address leaves it in place.
- R9: A request whose address has nonzero bits [1:0] (for example 0x12), or whose op code is 13 to 15, returns `rsp_err`=1 and `rsp_data`=0. It makes no memory request and leaves the reservation unchanged.
- R10: `req_aq` and `req_rl` have no effect on results, memory contents or timing.
- R11: Every legal aligned request returns `rsp_err`=0. A load returns the word, and a store writes it and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken on valid and ready |
| req_op | input | 4 | Operation code (R4) |
| req_aq | input | 1 | Acquire ordering hint, ignored |
| req_rl | input | 1 | Release ordering hint, ignored |
| req_addr | input | AW | Byte address, must be word aligned |
| req_wdata | input | DW | Store value or read-modify-write operand |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Old word, loaded word, or store-conditional code |
| rsp_err | output | 1 | Misaligned address or undefined op code |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
The assertions assume that the memory always accepts a request and returns read data exactly one cycle after a read request. They also assume that the core takes `rsp_valid` on the cycle it is shown, because the response channel has no ready. The bench respects both. Its memory model answers every read on the following edge. It offers each request only while the block is idle, and it collects each response in the cycle the model predicts. Misaligned and undefined requests are followed by loads of the same word, so an unwanted write would show up at the ports.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_LR    = 4'd2,
    OP_SC    = 4'd3,
    OP_SWAP  = 4'd4,
    OP_ADD   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_MIN   = 4'd9,
    OP_MAX   = 4'd10,
    OP_MINU  = 4'd11,
    OP_MAXU  = 4'd12
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MERGE,
    ST_WRITE,
    ST_RESP
  } rmw_state_e;

  localparam logic [3:0] LAST_OP = 4'd12;

  function automatic logic op_legal(input logic [3:0] op);
    return op <= LAST_OP;
  endfunction

  function automatic logic op_is_rmw(input logic [3:0] op);
    return (op >= 4'd4) && (op <= LAST_OP);
  endfunction
endpackage

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] new_val
);
  import atomic_pkg::*;

  always_comb begin
    case (rmw_op_e'(op))
      OP_ADD:  new_val = old_val + opnd;
      OP_AND:  new_val = old_val & opnd;
      OP_OR:   new_val = old_val | opnd;
      OP_XOR:  new_val = old_val ^ opnd;
      OP_MIN:  new_val = ($signed(old_val) < $signed(opnd)) ? old_val : opnd;
      OP_MAX:  new_val = ($signed(old_val) > $signed(opnd)) ? old_val : opnd;
      OP_MINU: new_val = (old_val < opnd) ? old_val : opnd;
      OP_MAXU: new_val = (old_val > opnd) ? old_val : opnd;
      default: new_val = opnd;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          sc_clr_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [AW-1:0] query_addr_i,
  output logic          hit_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr_i;
    end else if (sc_clr_i || (wr_i && (wr_addr_i == addr_q))) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o = valid_q && (addr_q == query_addr_i);

  // R7
  sc_clears_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr_i && !set_i) |=> !valid_q);

  // R8
  write_kills_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_o && (query_addr_i == wr_addr_i) && !set_i) |=> !valid_q);

  // R6
  lr_sets_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (valid_q && addr_q == $past(set_addr_i)));
endmodule

// File: rtl/amo_seq.sv
module amo_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    alu_op,
  output logic [DW-1:0] alu_old,
  output logic [DW-1:0] alu_opnd,
  input  logic [DW-1:0] alu_new,
  input  logic          resv_hit,
  output logic          resv_set,
  output logic          resv_sc_clr
);
  import atomic_pkg::*;

  localparam int OFFW = $clog2(DW / 8);

  rmw_state_e    state_q;
  logic [3:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] wval_q;
  logic          err_q;

  logic accept;
  logic bad_req;

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign bad_req = !op_legal(req_op) || (req_addr[OFFW-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      opnd_q  <= '0;
      data_q  <= '0;
      wval_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            opnd_q <= req_wdata;
            data_q <= '0;
            err_q  <= 1'b0;
            if (bad_req) begin
              err_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              case (rmw_op_e'(req_op))
                OP_STORE: begin
                  wval_q  <= req_wdata;
                  state_q <= ST_WRITE;
                end
                OP_SC: begin
                  if (resv_hit) begin
                    wval_q  <= req_wdata;
                    state_q <= ST_WRITE;
                  end else begin
                    data_q  <= DW'(1);
                    state_q <= ST_RESP;
                  end
                end
                default: state_q <= ST_READ;
              endcase
            end
          end
        end
        ST_READ:  state_q <= ST_MERGE;
        ST_MERGE: begin
          data_q <= mem_rdata;
          if (op_is_rmw(op_q)) begin
            wval_q  <= alu_new;
            state_q <= ST_WRITE;
          end else begin
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: state_q <= ST_RESP;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_data    = data_q;
  assign rsp_err     = err_q;
  assign mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wval_q;
  assign alu_op      = op_q;
  assign alu_old     = mem_rdata;
  assign alu_opnd    = opnd_q;
  assign resv_set    = (state_q == ST_MERGE) && (op_q == OP_LR);
  assign resv_sc_clr = accept && !bad_req && (req_op == OP_SC);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R2
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R1
  mem_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R5
  rmw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && op_is_rmw(op_q)) |=> !mem_req);

  // R5
  rmw_write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_MERGE) && op_is_rmw(op_q)) |=>
      (mem_req && mem_we && mem_addr == $past(mem_addr)));

  // R9
  bad_req_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_req) |=> (rsp_valid && rsp_err && !mem_req && rsp_data == '0));
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic          req_aq,
  input  logic          req_rl,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [3:0]    alu_op;
  logic [DW-1:0] alu_old;
  logic [DW-1:0] alu_opnd;
  logic [DW-1:0] alu_new;
  logic          resv_hit;
  logic          resv_set;
  logic          resv_sc_clr;
  logic          order_hint_unused;

  // R10: ordering hints are taken but have no effect
  assign order_hint_unused = req_aq ^ req_rl;

  amo_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_err     (rsp_err),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .alu_op      (alu_op),
    .alu_old     (alu_old),
    .alu_opnd    (alu_opnd),
    .alu_new     (alu_new),
    .resv_hit    (resv_hit),
    .resv_set    (resv_set),
    .resv_sc_clr (resv_sc_clr)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op      (alu_op),
    .old_val (alu_old),
    .opnd    (alu_opnd),
    .new_val (alu_new)
  );

  amo_resv #(.AW(AW)) u_resv (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (resv_set),
    .set_addr_i   (mem_addr),
    .sc_clr_i     (resv_sc_clr),
    .wr_i         (mem_req && mem_we),
    .wr_addr_i    (mem_addr),
    .query_addr_i (req_addr),
    .hit_o        (resv_hit)
  );
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_op = '0;
  logic          req_aq = 1'b0;
  logic          req_rl = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem_arr [NW];
  logic [DW-1:0] ref_mem [NW];
  logic          ref_rv;
  logic [AW-1:0] ref_ra;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  atomic_rmw_unit #(.AW(AW), .DW(DW)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_aq(req_aq), .req_rl(req_rl), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: read data returned on the edge after the request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_arr[mem_addr[5:2]] <= mem_wdata;
      else        mem_rdata <= mem_arr[mem_addr[5:2]];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_merge(input int op, input logic [DW-1:0] m,
                                              input logic [DW-1:0] w);
    case (op)
      5:  return m + w;
      6:  return m & w;
      7:  return m | w;
      8:  return m ^ w;
      9:  return ($signed(m) < $signed(w)) ? m : w;
      10: return ($signed(m) > $signed(w)) ? m : w;
      11: return (m < w) ? m : w;
      12: return (m > w) ? m : w;
      default: return w;
    endcase
  endfunction

  task automatic run(input int op, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                     input bit aq, input bit rl, input string tag);
    int idx = int'(addr[5:2]);
    int wait_n = 0;
    int exp_mem_n = 0;
    int got_mem_n = 0;
    logic [DW-1:0] exp_data = '0;
    bit exp_err = 1'b0;
    bit hit = ref_rv && (ref_ra == addr);
    if (op > 12 || addr[1:0] != 2'b00) begin
      exp_err = 1'b1;
    end else if (op == 0) begin
      exp_data = ref_mem[idx]; wait_n = 2; exp_mem_n = 1;
    end else if (op == 1) begin
      ref_mem[idx] = wd; if (hit) ref_rv = 1'b0; wait_n = 1; exp_mem_n = 1;
    end else if (op == 2) begin
      exp_data = ref_mem[idx]; ref_rv = 1'b1; ref_ra = addr; wait_n = 2; exp_mem_n = 1;
    end else if (op == 3) begin
      if (hit) begin
        ref_mem[idx] = wd; wait_n = 1; exp_mem_n = 1;
      end else begin
        exp_data = 1;
      end
      ref_rv = 1'b0;
    end else begin
      exp_data = ref_mem[idx];
      ref_mem[idx] = ref_merge(op, ref_mem[idx], wd);
      if (hit) ref_rv = 1'b0;
      wait_n = 3; exp_mem_n = 2;
    end

    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_addr = addr; req_wdata = wd;
    req_aq = aq; req_rl = rl;
    for (int k = 0; k <= wait_n; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (mem_req) got_mem_n++;
      chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 0);
      chk(rsp_valid == (k == wait_n), "R3", "rsp_valid timing", 64'(rsp_valid), 64'(k == wait_n));
      if (k == wait_n) begin
        chk(rsp_data == exp_data, tag, "rsp_data", 64'(rsp_data), 64'(exp_data));
        chk(rsp_err == exp_err, exp_err ? "R9" : "R11", "rsp_err", 64'(rsp_err), 64'(exp_err));
      end
    end
    chk(got_mem_n == exp_mem_n, exp_err ? "R9" : "R5", "memory request count",
        64'(got_mem_n), 64'(exp_mem_n));
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2", "idle after response", 64'({req_ready, rsp_valid}), 64'h2);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem_arr[i] = 32'h1000_0000 + 32'(i * 32'h0101);
      ref_mem[i] = mem_arr[i];
    end
    ref_rv = 1'b0;
    ref_ra = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "reset outputs",
        64'({req_ready, rsp_valid, mem_req}), 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0, "R1", "after reset release",
        64'({req_ready, mem_req}), 64'h2);

    run(3, 32'h08, 32'hDEAD, 0, 0, "R1");
    run(0, 32'h04, 0, 0, 0, "R11");
    run(1, 32'h04, 32'hCAFE_0004, 0, 0, "R11");
    run(0, 32'h04, 0, 0, 0, "R11");

    run(2, 32'h10, 0, 0, 0, "R6");
    run(3, 32'h10, 32'h1111_2222, 0, 0, "R7");
    run(3, 32'h10, 32'h3333_4444, 0, 0, "R7");
    run(2, 32'h10, 0, 0, 0, "R6");
    run(3, 32'h14, 32'h5555, 0, 0, "R7");
    run(3, 32'h10, 32'h6666, 0, 0, "R7");

    run(2, 32'h20, 0, 0, 0, "R6");
    run(1, 32'h24, 32'h0BAD_0024, 0, 0, "R8");
    run(3, 32'h20, 32'h7777, 0, 0, "R8");
    run(2, 32'h20, 0, 0, 0, "R6");
    run(1, 32'h20, 32'h0000_0020, 0, 0, "R8");
    run(3, 32'h20, 32'h8888, 0, 0, "R8");
    run(2, 32'h20, 0, 0, 0, "R6");
    run(5, 32'h20, 32'h3, 0, 0, "R8");
    run(3, 32'h20, 32'h9999, 0, 0, "R8");
    run(2, 32'h20, 0, 0, 0, "R6");
    run(2, 32'h28, 0, 0, 0, "R6");
    run(3, 32'h20, 32'hAAAA, 0, 0, "R6");
    run(3, 32'h28, 32'hBBBB, 0, 0, "R7");

    run(1, 32'h30, 32'hFFFF_FFFF, 0, 0, "R11");
    run(5, 32'h30, 32'h2, 0, 0, "R4");
    run(4, 32'h30, 32'hF0F0_1234, 0, 0, "R4");
    run(6, 32'h30, 32'h0FF0_FF00, 0, 0, "R4");
    run(7, 32'h30, 32'h8000_0001, 0, 0, "R4");
    run(8, 32'h30, 32'hFFFF_0000, 0, 0, "R4");
    run(1, 32'h34, 32'h0000_0005, 0, 0, "R11");
    run(9, 32'h34, 32'hFFFF_FFFE, 0, 0, "R4");
    run(10, 32'h34, 32'h0000_0007, 0, 0, "R4");
    run(11, 32'h34, 32'hFFFF_FFFE, 0, 0, "R4");
    run(12, 32'h34, 32'hFFFF_FFFE, 0, 0, "R4");
    run(9, 32'h34, 32'h0000_0003, 0, 0, "R4");
    run(11, 32'h34, 32'h0000_0001, 0, 0, "R4");

    run(2, 32'h38, 0, 0, 0, "R6");
    run(5, 32'h12, 32'h1, 0, 0, "R9");
    run(1, 32'h06, 32'h1234, 0, 0, "R9");
    run(13, 32'h38, 32'h1, 0, 0, "R9");
    run(15, 32'h38, 32'h1, 0, 0, "R9");
    run(0, 32'h10, 0, 0, 0, "R9");
    run(0, 32'h04, 0, 0, 0, "R9");
    run(3, 32'h38, 32'hC0DE, 0, 0, "R9");

    run(4, 32'h3C, 32'h1357, 1, 0, "R10");
    run(5, 32'h3C, 32'h1, 1, 1, "R10");
    run(2, 32'h3C, 0, 0, 1, "R10");
    run(3, 32'h3C, 32'h2468, 1, 1, "R10");
    run(0, 32'h3C, 0, 1, 0, "R10");

    for (int i = 0; i < NW; i++)
      chk(mem_arr[i] == ref_mem[i], "R4", "final memory word", 64'(mem_arr[i]), 64'(ref_mem[i]));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule